// File: doc/BRIEF.md
# LFSR Ratio Codec

The block translates in both directions between a plain integer divide or multiply ratio and the state code that a counter-based clock divider built from a linear feedback shift register expects. Such a divider loads the code into its register and counts by shifting it. The ratio is therefore written as the register state reached after a ratio-dependent number of shifts from a fixed start value, not as a binary count. The three smallest ratios have fixed reserved codes.

Three register variants are served, chosen per operation by `mode`. The pre-divide variant has an 8-bit register and a 10-bit code field. The post-divide variant has a 5-bit register and a 7-bit code field. The feedback-multiply variant has a 15-bit register and a 17-bit code field. A single `start` pulse launches one conversion, with `dir` selecting encode (ratio to code) or decode (code to ratio). The engine then shifts its own copy of the register once per cycle. It raises `done` for one cycle when `result` is valid. Reserved values and out-of-range inputs take a short path that finishes without shifting.

Top module: `lfsr_ratio_codec`

## Requirements
- R1: Mode 0 (pre-divide): the register is 8 bits wide and starts at 0x80. Each shift moves it right by one and fills bit 7 with the XOR of bits 0, 2, 3 and 4. The maximum ratio is 256. Encoding a ratio v with 3 <= v <= 256 applies 256 - v + 1 shifts and returns the register value, zero-extended.
- R2: Mode 1 (post-divide): the register is 5 bits wide and starts at 0x10. Each shift moves it right by one and fills bit 4 with the XOR of bits 0 and 2. The maximum ratio is 32, and encoding applies 32 - v + 1 shifts.
- R3: Mode 2 (multiply): the register is 15 bits wide and starts at 0x4000. Each shift moves it right by one and fills bit 14 with the XOR of bits 0 and 1. The maximum ratio is 32768, and encoding applies 32768 - v + 1 shifts.
- R4: Encoding ratios 0, 1 and 2 returns fixed codes, already masked to the code field. Mode 0 gives 0x3FF, 0x302 and 0x202. Mode 1 gives 0x7F, 0x62 and 0x42. Mode 2 gives 0x1FFFF, 0x18003 and 0x10003. Encoding a ratio above the variant's maximum applies no shift and returns the start value.
- R5: Decoding first masks `value_in` to the code field of the variant (10, 7 or 17 bits). A masked code equal to one of the fixed codes of R4 returns 0, 1 or 2. Otherwise the engine shifts from the start value once per candidate, counting the candidate down from the maximum to 3. It returns the first candidate whose register state equals the masked code.
- R6: A decode that reaches candidate 3 without a match sets `err` and returns all ones (0x1FFFF). Any operation that succeeds clears `err`.
- R7: Mode 3 is not a variant. In either direction it finishes without shifting, sets `err` and returns 0x1FFFF.
- R8: `busy` is high while the engine shifts. `done` rises S + 1 cycles after the clock edge that accepts `start`, where S is the number of shifts defined above (0 on the short path, and max - 2 for a decode that finds no match).
- R9: A `start` pulse while `busy` is high has no effect on the running operation or its result.
- R10: `done` is high for exactly one cycle per accepted operation. `result` and `err` change only in that cycle and hold until the next one.
- R11: After reset, `busy`, `done` and `err` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch one conversion; taken only when not busy |
| mode | input | 2 | Variant: 0 pre-divide, 1 post-divide, 2 multiply, 3 invalid |
| dir | input | 1 | 0 encode ratio to code, 1 decode code to ratio |
| value_in | input | 17 | Ratio to encode, or code to decode |
| busy | output | 1 | Engine is shifting |
| done | output | 1 | One-cycle pulse: result and err are valid |
| err | output | 1 | Last operation failed (no match or invalid mode) |
| result | output | 17 | Code, or decoded ratio |

## Verification
On every cycle, the assertions check the following. `done` and `busy` never overlap. `done` only follows an accepted start or a shifting cycle. `result` and `err` hold between completions. An error always carries the all-ones result. The short path completes on the next cycle, and a start during a run leaves the latched operation unchanged. Some properties can only be shown by the bench's scenarios: that a code is the correct register state for each of the three feedback polynomials, that decode returns the first matching candidate, that the fixed codes map both ways, and that each completion lands exactly S + 1 cycles after start.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  localparam int DATA_W    = 17;
  localparam int REG_MAX_W = 15;
  localparam int CNT_W     = 16;
  localparam int NUM_VAR   = 3;

  typedef enum logic [1:0] {VAR_N = 2'd0, VAR_P = 2'd1, VAR_M = 2'd2, VAR_NONE = 2'd3} var_e;
  typedef logic [DATA_W-1:0]    word_t;
  typedef logic [REG_MAX_W-1:0] lfsr_t;
  typedef logic [CNT_W-1:0]     cnt_t;

  function automatic int reg_w(logic [1:0] v);
    case (v)
      2'd0:    return 8;
      2'd1:    return 5;
      default: return 15;
    endcase
  endfunction

  function automatic lfsr_t taps(logic [1:0] v);
    case (v)
      2'd0:    return 15'h001D;
      2'd1:    return 15'h0005;
      default: return 15'h0003;
    endcase
  endfunction

  function automatic lfsr_t seed(logic [1:0] v);
    case (v)
      2'd0:    return 15'h0080;
      2'd1:    return 15'h0010;
      default: return 15'h4000;
    endcase
  endfunction

  function automatic cnt_t max_ratio(logic [1:0] v);
    case (v)
      2'd0:    return 16'd256;
      2'd1:    return 16'd32;
      default: return 16'd32768;
    endcase
  endfunction

  function automatic word_t code_mask(logic [1:0] v);
    case (v)
      2'd0:    return 17'h003FF;
      2'd1:    return 17'h0007F;
      default: return 17'h1FFFF;
    endcase
  endfunction

  // fixed codes for ratios 0..2, already masked to the code field
  function automatic word_t rsv_code(logic [1:0] v, logic [1:0] r);
    case ({v, r})
      4'b00_00: return 17'h003FF;
      4'b00_01: return 17'h00302;
      4'b00_10: return 17'h00202;
      4'b01_00: return 17'h0007F;
      4'b01_01: return 17'h00062;
      4'b01_10: return 17'h00042;
      4'b10_00: return 17'h1FFFF;
      4'b10_01: return 17'h18003;
      4'b10_10: return 17'h10003;
      default:  return 17'h1FFFF;
    endcase
  endfunction
endpackage

// File: rtl/lrc_step.sv
module lrc_step #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic fb;
  always_comb begin
    fb  = ^(cur & TAPS);
    nxt = {fb, cur[W-1:1]};
  end
endmodule

// File: rtl/lrc_step_bank.sv
module lrc_step_bank
  import lrc_pkg::*;
(
  input  logic [1:0] sel,
  input  lfsr_t      cur,
  output lfsr_t      nxt
);
  lfsr_t bank [NUM_VAR];

  for (genvar g = 0; g < NUM_VAR; g++) begin : g_var
    localparam int    W        = reg_w(2'(g));
    localparam lfsr_t TAP_FULL = taps(2'(g));
    logic [W-1:0] nxt_w;
    lrc_step #(.W(W), .TAPS(TAP_FULL[W-1:0])) u_step (
      .cur(cur[W-1:0]),
      .nxt(nxt_w)
    );
    assign bank[g] = lfsr_t'(nxt_w);
  end

  always_comb begin
    case (sel)
      2'd0:    nxt = bank[0];
      2'd1:    nxt = bank[1];
      2'd2:    nxt = bank[2];
      default: nxt = '0;
    endcase
  end
endmodule

// File: rtl/lrc_shortcut.sv
module lrc_shortcut
  import lrc_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       dir,
  input  word_t      value,
  output logic       hit,
  output word_t      hit_res,
  output logic       hit_err,
  output cnt_t       run_cnt,
  output word_t      code_m
);
  cnt_t mx;

  always_comb begin
    hit     = 1'b0;
    hit_res = '0;
    hit_err = 1'b0;
    run_cnt = '0;
    mx      = max_ratio(mode);
    code_m  = value & code_mask(mode);
    if (mode == VAR_NONE) begin
      hit     = 1'b1;
      hit_err = 1'b1;
      hit_res = '1;
    end else if (!dir) begin
      if (value <= word_t'(2)) begin
        hit     = 1'b1;
        hit_res = rsv_code(mode, value[1:0]);
      end else if (value > {1'b0, mx}) begin
        hit     = 1'b1;
        hit_res = word_t'(seed(mode));
      end else begin
        run_cnt = mx - value[CNT_W-1:0] + cnt_t'(1);
      end
    end else begin
      if (code_m == rsv_code(mode, 2'd0)) begin
        hit = 1'b1; hit_res = word_t'(0);
      end else if (code_m == rsv_code(mode, 2'd1)) begin
        hit = 1'b1; hit_res = word_t'(1);
      end else if (code_m == rsv_code(mode, 2'd2)) begin
        hit = 1'b1; hit_res = word_t'(2);
      end else begin
        run_cnt = mx;
      end
    end
  end
endmodule

// File: rtl/lrc_engine.sv
module lrc_engine
  import lrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic       dir,
  input  logic       hit,
  input  word_t      hit_res,
  input  logic       hit_err,
  input  cnt_t       run_cnt,
  input  word_t      code_m,
  input  lfsr_t      step_nxt,
  output logic [1:0] mode_q,
  output lfsr_t      lfsr_q,
  output logic       busy,
  output logic       done,
  output logic       err,
  output word_t      result
);
  logic  busy_q, done_q, err_q, dir_q;
  word_t res_q, code_q;
  cnt_t  cnt_q;

  // named events
  logic accept, enc_last, dec_match, dec_exhaust;
  assign accept      = start && !busy_q;
  assign enc_last    = busy_q && !dir_q && (cnt_q == cnt_t'(1));
  assign dec_match   = busy_q && dir_q && (word_t'(step_nxt) == code_q);
  assign dec_exhaust = busy_q && dir_q && !dec_match && (cnt_q == cnt_t'(3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      dir_q  <= 1'b0;
      mode_q <= 2'd0;
      res_q  <= '0;
      code_q <= '0;
      cnt_q  <= '0;
      lfsr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        mode_q <= mode;
        dir_q  <= dir;
        code_q <= code_m;
        if (hit) begin
          res_q  <= hit_res;
          err_q  <= hit_err;
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= run_cnt;
          lfsr_q <= seed(mode);
        end
      end else if (busy_q) begin
        lfsr_q <= step_nxt;
        if (enc_last) begin
          res_q  <= word_t'(step_nxt);
          err_q  <= 1'b0;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else if (dec_match) begin
          res_q  <= word_t'(cnt_q);
          err_q  <= 1'b0;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else if (dec_exhaust) begin
          res_q  <= '1;
          err_q  <= 1'b1;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - cnt_t'(1);
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign err    = err_q;
  assign result = res_q;

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R8
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(accept || busy_q)); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(res_q) && $stable(err_q))); // R10
  AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q) |-> (res_q == '1)); // R6
  AST_SHORT_PATH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (done_q && !busy_q)); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(mode_q) && $stable(code_q) && $stable(dir_q))); // R9
  AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && dir_q) |-> (cnt_q >= cnt_t'(3))); // R5
  AST_ENC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !dir_q) |-> (cnt_q >= cnt_t'(1))); // R8
  AST_RUN_MODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (mode_q != VAR_NONE)); // R7
endmodule

// File: rtl/lfsr_ratio_codec.sv
module lfsr_ratio_codec
  import lrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              dir,
  input  logic [DATA_W-1:0] value_in,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] result
);
  logic       hit, hit_err;
  word_t      hit_res, code_m;
  cnt_t       run_cnt;
  logic [1:0] mode_q;
  lfsr_t      lfsr_q, step_nxt;

  lrc_shortcut u_short (
    .mode(mode), .dir(dir), .value(value_in),
    .hit(hit), .hit_res(hit_res), .hit_err(hit_err),
    .run_cnt(run_cnt), .code_m(code_m)
  );

  lrc_step_bank u_bank (
    .sel(mode_q), .cur(lfsr_q), .nxt(step_nxt)
  );

  lrc_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dir(dir),
    .hit(hit), .hit_res(hit_res), .hit_err(hit_err),
    .run_cnt(run_cnt), .code_m(code_m), .step_nxt(step_nxt),
    .mode_q(mode_q), .lfsr_q(lfsr_q),
    .busy(busy), .done(done), .err(err), .result(result)
  );
endmodule

// File: tb/tb_lfsr_ratio_codec.sv
`timescale 1ns/1ps
module tb_lfsr_ratio_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dir = 1'b0;
  logic [16:0] value_in = '0;
  logic        busy, done, err;
  logic [16:0] result;

  int n_total = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  lfsr_ratio_codec dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dir(dir),
    .value_in(value_in), .busy(busy), .done(done), .err(err), .result(result)
  );

  // ---------------- reference model ----------------
  function automatic int b_max(int m);
    return (m == 0) ? 256 : (m == 1) ? 32 : 32768;
  endfunction
  function automatic int b_seed(int m);
    return (m == 0) ? 'h80 : (m == 1) ? 'h10 : 'h4000;
  endfunction
  function automatic int b_mask(int m);
    return (m == 0) ? 'h3FF : (m == 1) ? 'h7F : 'h1FFFF;
  endfunction
  function automatic int b_shift(int m, int x);
    int bit_in;
    if (m == 0) begin
      bit_in = ((x >> 0) ^ (x >> 2) ^ (x >> 3) ^ (x >> 4)) & 1;
      return (bit_in << 7) | (x >> 1);
    end else if (m == 1) begin
      bit_in = (x ^ (x >> 2)) & 1;
      return (bit_in << 4) | (x >> 1);
    end
    bit_in = (x ^ (x >> 1)) & 1;
    return (bit_in << 14) | (x >> 1);
  endfunction
  function automatic int b_fixed(int m, int r);
    int t [3][3] = '{'{'h3FF, 'h302, 'h202}, '{'h7F, 'h62, 'h42}, '{'h1FFFF, 'h18003, 'h10003}};
    return t[m][r];
  endfunction

  task automatic b_encode(input int m, input int v, output int res, output int steps);
    int x;
    if (v <= 2) begin res = b_fixed(m, v); steps = 0; return; end
    if (v > b_max(m)) begin res = b_seed(m); steps = 0; return; end
    x = b_seed(m);
    for (int i = v; i <= b_max(m); i++) x = b_shift(m, x);
    res = x & b_mask(m);
    steps = b_max(m) - v + 1;
  endtask

  task automatic b_decode(input int m, input int c, output int res, output bit e, output int steps);
    int x;
    c = c & b_mask(m);
    e = 1'b0;
    for (int r = 0; r < 3; r++)
      if (c == b_fixed(m, r)) begin res = r; steps = 0; return; end
    x = b_seed(m);
    for (int i = b_max(m); i >= 3; i--) begin
      x = b_shift(m, x);
      if (x == c) begin res = i; steps = b_max(m) - i + 1; return; end
    end
    res = 'h1FFFF; e = 1'b1; steps = b_max(m) - 2;
  endtask

  // ---------------- checking ----------------
  task automatic chk(input string tag, input int got, input int exp);
    n_total++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic run_op(input int m, input bit d, input int v,
                        input int exp_res, input bit exp_err, input int exp_steps, input string tag);
    int lat;
    @(negedge clk);
    mode = 2'(m); dir = d; value_in = 17'(v); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40000) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " result"}, int'(result), exp_res);
    chk({tag, " err"}, int'(err), int'(exp_err));
    chk({tag, " latency R8"}, lat, exp_steps + 1);
  endtask

  task automatic enc_check(input int m, input int v, input string tag);
    int r, s;
    b_encode(m, v, r, s);
    run_op(m, 1'b0, v, r, 1'b0, s, tag);
  endtask

  task automatic dec_check(input int m, input int c, input string tag);
    int r, s;
    bit e;
    b_decode(m, c, r, e, s);
    run_op(m, 1'b1, c, r, e, s, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int r, s, code, held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 err", int'(err), 0);
    chk("R11 result", int'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 pre-divide variant
    enc_check(0, 3, "R1 enc3");
    enc_check(0, 256, "R1 enc256");
    enc_check(0, 100, "R1 enc100");
    b_encode(0, 77, code, s);
    dec_check(0, code, "R1 roundtrip77");
    // R2 post-divide variant
    enc_check(1, 3, "R2 enc3");
    enc_check(1, 32, "R2 enc32");
    enc_check(1, 17, "R2 enc17");
    b_encode(1, 9, code, s);
    dec_check(1, code, "R2 roundtrip9");
    // R3 multiply variant
    enc_check(2, 32768, "R3 enc32768");
    enc_check(2, 32700, "R3 enc32700");
    enc_check(2, 3, "R3 enc3");
    b_encode(2, 3, code, s);
    dec_check(2, code, "R3 roundtrip3");

    // R4 fixed codes and above-maximum ratios
    for (int m = 0; m < 3; m++)
      for (int v = 0; v < 3; v++) enc_check(m, v, "R4 fixed");
    enc_check(0, 300, "R4 above max N");
    enc_check(1, 33, "R4 above max P");
    enc_check(2, 40000, "R4 above max M");

    // R5 fixed codes decode, bits above the code field are masked
    for (int m = 0; m < 3; m++)
      for (int v = 0; v < 3; v++) dec_check(m, b_fixed(m, v), "R5 fixed decode");
    dec_check(0, 'h1302, "R5 masked upper bits");
    b_encode(1, 20, code, s);
    dec_check(1, code | 'h1F00, "R5 masked roundtrip");

    // R6 no match: start value is outside the search window
    dec_check(0, 'h80, "R6 seed N");
    dec_check(0, 'h100, "R6 wide N");
    dec_check(1, 'h10, "R6 seed P");
    dec_check(2, 'h4000, "R6 seed M");
    enc_check(0, 50, "R6 err cleared");

    // R7 invalid mode
    run_op(3, 1'b0, 5, 'h1FFFF, 1'b1, 0, "R7 invalid enc");
    run_op(3, 1'b1, 'h302, 'h1FFFF, 1'b1, 0, "R7 invalid dec");

    // R9 start during a run is ignored
    b_encode(0, 3, r, s);
    @(negedge clk);
    mode = 2'd0; dir = 1'b0; value_in = 17'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    mode = 2'd1; dir = 1'b1; value_in = 17'h62; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 still busy", int'(busy), 1);
    chk("R9 no early done", int'(done), 0);
    held = 7;
    while (!done && held < 1000) begin @(negedge clk); held++; end
    chk("R9 result", int'(result), r);
    chk("R9 latency", held, s + 1);

    // R10 done is a pulse and result holds
    @(negedge clk);
    chk("R10 done pulse", int'(done), 0);
    repeat (8) @(negedge clk);
    chk("R10 result hold", int'(result), r);
    chk("R10 done low", int'(done), 0);

    // random mix
    for (int k = 0; k < 60; k++) begin
      int m, v;
      m = int'($urandom % 3);
      if ($urandom % 2 == 0) begin
        if (m == 2) v = 32768 - int'($urandom % 300);
        else if (m == 1) v = int'($urandom % 36);
        else v = int'($urandom % 260);
        enc_check(m, v, "R1 R2 R3 random encode");
      end else begin
        if (m == 2) begin
          b_encode(2, 32768 - int'($urandom % 300), code, s);
        end else if ($urandom % 2 == 0) begin
          code = int'($urandom) & 'h1FFFF;
        end else begin
          b_encode(m, 3 + int'($urandom % (b_max(m) - 2)), code, s);
        end
        dec_check(m, code, "R5 R6 random decode");
      end
    end

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
    $finish;
  end
endmodule